// File: doc/BRIEF.md
# Dual-Core Hardware Semaphore and Mailbox Unit

This block lets two processor cores share resources safely. Each core has its own port on a simple 32-bit register bus, and each port can make one access per cycle. The block holds eight one-bit semaphores. A core claims a semaphore by reading its word. That read returns the previous value of the flag and sets the flag, all in one access. A core releases the semaphore by writing zero. One status word shows all eight flags together.

Each core also owns a 32-bit mailbox and an interrupt-control word. One core can put a word in the other core's mailbox and set that core's interrupt flag. The interrupt line of a core is high when its flag and its enable are both set.

When both ports access the block in the same cycle, port 0 takes effect first. Port 1 then sees the state that port 0 left. This order settles every contention with a fixed priority. Read data appears on the port's `rdata_o` in the cycle after the read and is held until the next read on that port.

Top module: `sema_mbox_top`

## Requirements
- R1: Reading a semaphore word (byte offsets 0x00, 0x04, ..., 0x1C, flag in bit 0, word n is semaphore n) returns the flag as it stood before the read, in bit 0 with all other bits zero, and leaves the flag set to 1.
- R2: Writing a semaphore word with bit 0 = 0 clears that semaphore. Writing it with bit 0 = 1 changes nothing.
- R3: A read of offset 0x100 returns semaphore n in bit n (bits 7:0, 1 = taken, upper bits zero) and changes no flag. Writes to 0x100 are ignored.
- R4: When both ports read the same free semaphore in one cycle, port 0 gets 0 and port 1 gets 1, and the semaphore ends up set.
- R5: The interrupt-control word of core 0 is at 0x40 and that of core 1 is at 0x48. In each word, bit 0 is the enable and bit 16 is the flag. A write loads both bits, and a read returns them with all other bits zero.
- R6: `irq_o[c]` is 1 exactly in the cycle after core c's flag and enable are both 1.
- R7: The mailbox of core 0 is at 0x44 and the mailbox of core 1 is at 0x4C. Each is a full 32-bit read/write register that either port may access.
- R8: Words in 0x20–0x3C and 0x50–0xFC read as zero, and writes to them change no state.
- R9: After reset, all semaphores, mailboxes, enables, flags and interrupt outputs are zero.
- R10: In a cycle where both ports are active, port 0's access is applied first and port 1 sees its result. If port 0 clears a semaphore that port 1 reads, port 1 gets 0 and the semaphore stays set. If both ports write one register, port 1's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_CORES | Per-port access request |
| we_i | input | NUM_CORES | Per-port write enable (0 = read) |
| addr_i | input | NUM_CORES x ADDR_W | Per-port byte address; bits 1:0 ignored |
| wdata_i | input | NUM_CORES x DATA_W | Per-port write data |
| rdata_o | output | NUM_CORES x DATA_W | Per-port read data, valid the cycle after a read |
| irq_o | output | NUM_CORES | Registered interrupt line for each core |

## Verification
The bench builds the block with its default parameters: eight semaphores, two cores, 32-bit data and a 12-bit address. This makes a full sweep possible. The sweep covers every semaphore word from each port, every contention pairing of the two ports on each semaphore, all four enable/flag combinations for each core, and every reserved word in both gaps. The expected read data, status words and interrupt levels come from a small register model in the bench. That model applies port 0's access before port 1's.

// File: rtl/sema_pkg.sv
package sema_pkg;
  localparam int unsigned IRQ_BASE_WORD = 'h40 >> 2;
  localparam int unsigned STATUS_WORD   = 'h100 >> 2;
  localparam int unsigned EN_BIT        = 0;
  localparam int unsigned FLAG_BIT      = 16;

  function automatic int unsigned irq_word(input int unsigned core);
    return IRQ_BASE_WORD + 2 * core;
  endfunction

  function automatic int unsigned mbox_word(input int unsigned core);
    return IRQ_BASE_WORD + 2 * core + 1;
  endfunction
endpackage

// File: rtl/sema_access_stage.sv
// Applies one port's access to a snapshot of the register state.
module sema_access_stage
  import sema_pkg::*;
#(
  parameter int unsigned NUM_SEMA  = 8,
  parameter int unsigned NUM_CORES = 2,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic                              req_i,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  input  logic [NUM_SEMA-1:0]               sema_i,
  input  logic [NUM_CORES-1:0][DATA_W-1:0]  mbox_i,
  input  logic [NUM_CORES-1:0]              en_i,
  input  logic [NUM_CORES-1:0]              flag_i,
  output logic [NUM_SEMA-1:0]               sema_o,
  output logic [NUM_CORES-1:0][DATA_W-1:0]  mbox_o,
  output logic [NUM_CORES-1:0]              en_o,
  output logic [NUM_CORES-1:0]              flag_o,
  output logic [DATA_W-1:0]                 rdata_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned SIDX_W = $clog2(NUM_SEMA);

  logic [WORD_W-1:0] word;
  logic [SIDX_W-1:0] sidx;
  logic              rd_en;

  assign word  = addr_i[ADDR_W-1:2];
  assign sidx  = word[SIDX_W-1:0];
  assign rd_en = req_i && !we_i;

  always_comb begin
    sema_o  = sema_i;
    mbox_o  = mbox_i;
    en_o    = en_i;
    flag_o  = flag_i;
    rdata_o = '0;
    if (req_i) begin
      if (word < WORD_W'(NUM_SEMA)) begin
        if (rd_en) begin
          rdata_o[0]   = sema_i[sidx];
          sema_o[sidx] = 1'b1;
        end else if (!wdata_i[0]) begin
          sema_o[sidx] = 1'b0;
        end
      end
      if (rd_en && word == WORD_W'(STATUS_WORD)) rdata_o[NUM_SEMA-1:0] = sema_i;
      for (int c = 0; c < NUM_CORES; c++) begin
        if (word == WORD_W'(irq_word(c))) begin
          if (rd_en) begin
            rdata_o[FLAG_BIT] = flag_i[c];
            rdata_o[EN_BIT]   = en_i[c];
          end else begin
            en_o[c]   = wdata_i[EN_BIT];
            flag_o[c] = wdata_i[FLAG_BIT];
          end
        end
        if (word == WORD_W'(mbox_word(c))) begin
          if (rd_en) rdata_o = mbox_i[c];
          else       mbox_o[c] = wdata_i;
        end
      end
    end
  end
endmodule

// File: rtl/sema_irq_out.sv
module sema_irq_out #(
  parameter int unsigned NUM_CORES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CORES-1:0] en_i,
  input  logic [NUM_CORES-1:0] flag_i,
  output logic [NUM_CORES-1:0] irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= '0;
    else         irq_o <= en_i & flag_i;
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    a_r6_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i[c] && flag_i[c]) |=> irq_o[c]);
    a_r6_irq_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(en_i[c] && flag_i[c]) |=> !irq_o[c]);
  end
endmodule

// File: rtl/sema_mbox_top.sv
module sema_mbox_top
  import sema_pkg::*;
#(
  parameter int unsigned NUM_SEMA  = 8,
  parameter int unsigned NUM_CORES = 2,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_CORES-1:0]              req_i,
  input  logic [NUM_CORES-1:0]              we_i,
  input  logic [NUM_CORES-1:0][ADDR_W-1:0]  addr_i,
  input  logic [NUM_CORES-1:0][DATA_W-1:0]  wdata_i,
  output logic [NUM_CORES-1:0][DATA_W-1:0]  rdata_o,
  output logic [NUM_CORES-1:0]              irq_o
);
  localparam int unsigned SIDX_W = $clog2(NUM_SEMA);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [NUM_SEMA-1:0]              sema_q;
  logic [NUM_CORES-1:0][DATA_W-1:0] mbox_q;
  logic [NUM_CORES-1:0]             en_q, flag_q;

  // Port c sees the state left by ports 0..c-1 in the same cycle.
  logic [NUM_SEMA-1:0]              ch_sema [NUM_CORES+1];
  logic [NUM_CORES-1:0][DATA_W-1:0] ch_mbox [NUM_CORES+1];
  logic [NUM_CORES-1:0]             ch_en   [NUM_CORES+1];
  logic [NUM_CORES-1:0]             ch_flag [NUM_CORES+1];
  logic [NUM_CORES-1:0][DATA_W-1:0] rd_next;

  assign ch_sema[0] = sema_q;
  assign ch_mbox[0] = mbox_q;
  assign ch_en[0]   = en_q;
  assign ch_flag[0] = flag_q;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_port
    sema_access_stage #(
      .NUM_SEMA(NUM_SEMA), .NUM_CORES(NUM_CORES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) stage_i (
      .req_i  (req_i[c]),
      .we_i   (we_i[c]),
      .addr_i (addr_i[c]),
      .wdata_i(wdata_i[c]),
      .sema_i (ch_sema[c]),
      .mbox_i (ch_mbox[c]),
      .en_i   (ch_en[c]),
      .flag_i (ch_flag[c]),
      .sema_o (ch_sema[c+1]),
      .mbox_o (ch_mbox[c+1]),
      .en_o   (ch_en[c+1]),
      .flag_o (ch_flag[c+1]),
      .rdata_o(rd_next[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 rdata_o[c] <= '0;
      else if (req_i[c] && !we_i[c]) rdata_o[c] <= rd_next[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sema_q <= '0;
      mbox_q <= '0;
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      sema_q <= ch_sema[NUM_CORES];
      mbox_q <= ch_mbox[NUM_CORES];
      en_q   <= ch_en[NUM_CORES];
      flag_q <= ch_flag[NUM_CORES];
    end
  end

  sema_irq_out #(.NUM_CORES(NUM_CORES)) irq_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_q),
    .flag_i(flag_q),
    .irq_o (irq_o)
  );

  logic p0_sema_rd, p0_sema_wr1, p0_status_wr, p1_idle, both_same_rd;
  assign p0_sema_rd   = req_i[0] && !we_i[0] && addr_i[0][ADDR_W-1:2] < WORD_W'(NUM_SEMA);
  assign p0_sema_wr1  = req_i[0] && we_i[0] && wdata_i[0][0]
                        && addr_i[0][ADDR_W-1:2] < WORD_W'(NUM_SEMA);
  assign p0_status_wr = req_i[0] && we_i[0] && addr_i[0][ADDR_W-1:2] == WORD_W'(STATUS_WORD);
  assign p1_idle      = !req_i[1];
  assign both_same_rd = p0_sema_rd && req_i[1] && !we_i[1]
                        && addr_i[1][ADDR_W-1:2] == addr_i[0][ADDR_W-1:2];

  a_r1_read_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p0_sema_rd |=> sema_q[$past(addr_i[0][SIDX_W+1:2])]);
  a_r1_read_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p0_sema_rd && !sema_q[addr_i[0][SIDX_W+1:2]]) |=> rdata_o[0] == '0);
  a_r2_write_one_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p0_sema_wr1 && p1_idle) |=> $stable(sema_q));
  a_r3_status_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p0_status_wr && p1_idle) |=> ($stable(sema_q) && $stable(mbox_q)));
  a_r4_single_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (both_same_rd && !sema_q[addr_i[0][SIDX_W+1:2]])
      |=> (rdata_o[0][0] == 1'b0 && rdata_o[1][0] == 1'b1));
endmodule

// File: tb/sema_mbox_top_tb_top.sv
`timescale 1ns/1ps
module sema_mbox_top_tb_top;
  localparam int NS = 8, NC = 2, DW = 32, AW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC-1:0] req = '0, we = '0;
  logic [NC-1:0][AW-1:0] addr = '0;
  logic [NC-1:0][DW-1:0] wdata = '0;
  logic [NC-1:0][DW-1:0] rdata;
  logic [NC-1:0] irq;

  int n_tests = 0, n_fail = 0;
  logic [NS-1:0] m_sema = '0;
  logic [DW-1:0] m_mbox [NC];

  always #2 clk = ~clk;

  sema_mbox_top #(.NUM_SEMA(NS), .NUM_CORES(NC), .DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc2(input logic r0, w0, input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                      input logic r1, w1, input logic [AW-1:0] a1, input logic [DW-1:0] d1,
                      output logic [DW-1:0] q0, output logic [DW-1:0] q1);
    @(negedge clk);
    req = {r1, r0}; we = {w1, w0};
    addr[0] = a0; addr[1] = a1; wdata[0] = d0; wdata[1] = d1;
    @(negedge clk);
    req = '0; we = '0;
    q0 = rdata[0]; q1 = rdata[1];
  endtask

  task automatic rd(input int c, input logic [AW-1:0] a, output logic [DW-1:0] q);
    logic [DW-1:0] x0, x1;
    if (c == 0) cyc2(1, 0, a, 0, 0, 0, 0, 0, x0, x1);
    else        cyc2(0, 0, 0, 0, 1, 0, a, 0, x0, x1);
    q = (c == 0) ? x0 : x1;
  endtask

  task automatic wr(input int c, input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] x0, x1;
    if (c == 0) cyc2(1, 1, a, d, 0, 0, 0, 0, x0, x1);
    else        cyc2(0, 0, 0, 0, 1, 1, a, d, x0, x1);
  endtask

  task automatic chk_status(input string tag);
    logic [DW-1:0] q;
    rd(1, 12'h100, q);
    chk(tag, q, {{(DW-NS){1'b0}}, m_sema});
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] q, q0, q1;
    logic [DW-1:0] pats [4];
    m_mbox[0] = '0; m_mbox[1] = '0;
    pats[0] = 32'hA5A5_5A5A; pats[1] = 32'h5A5A_A5A5; pats[2] = 32'hFFFF_FFFF; pats[3] = 32'h0000_0001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    chk("R9 irq after reset", {30'b0, irq}, 0);
    chk_status("R9 status after reset");
    for (int c = 0; c < NC; c++) begin
      rd(c, 12'h44 + 12'(8 * c), q); chk("R9 mailbox after reset", q, 0);
      rd(c, 12'h40 + 12'(8 * c), q); chk("R9 irq ctrl after reset", q, 0);
    end

    // R1 claim each semaphore twice, alternating ports
    for (int i = 0; i < NS; i++) begin
      rd(i % 2, 12'(4 * i), q);       chk("R1 first read old value", q, 0);
      m_sema[i] = 1'b1;
      rd((i + 1) % 2, 12'(4 * i), q); chk("R1 second read sees set", q, 1);
      chk_status("R3 status tracks claims");
    end
    // R2 write 1 no effect, R3 status write ignored
    for (int i = 0; i < NS; i++) wr(i % 2, 12'(4 * i), 32'hFFFF_FFFF);
    chk_status("R2 write one keeps flags");
    wr(0, 12'h100, 32'h0); wr(1, 12'h100, 32'h0);
    chk_status("R3 status write ignored");
    // R2 clear even semaphores
    for (int i = 0; i < NS; i += 2) begin wr(i % 4 / 2, 12'(4 * i), 32'hFFFF_FFFE); m_sema[i] = 1'b0; end
    chk_status("R2 write zero clears");
    for (int i = 0; i < NS; i++) begin wr(1, 12'(4 * i), 0); m_sema[i] = 1'b0; end
    chk_status("R2 all cleared");

    // R4 and R10 contention sweep
    for (int i = 0; i < NS; i++) begin
      cyc2(1, 0, 12'(4 * i), 0, 1, 0, 12'(4 * i), 0, q0, q1);
      chk("R4 port0 wins", q0, 0);
      chk("R4 port1 loses", q1, 1);
      m_sema[i] = 1'b1;
      chk_status("R4 semaphore set after contention");
      cyc2(1, 1, 12'(4 * i), 0, 1, 0, 12'(4 * i), 0, q0, q1);
      chk("R10 port1 sees port0 clear", q1, 0);
      chk_status("R10 flag set after clear then read");
      wr(0, 12'(4 * i), 0); m_sema[i] = 1'b0;
    end

    // R7 mailboxes
    foreach (pats[p]) begin
      for (int c = 0; c < NC; c++) begin
        wr(1 - c, 12'h44 + 12'(8 * c), pats[p] ^ DW'(c));
        m_mbox[c] = pats[p] ^ DW'(c);
      end
      for (int c = 0; c < NC; c++) begin
        rd(c, 12'h44 + 12'(8 * c), q); chk("R7 mailbox readback", q, m_mbox[c]);
      end
    end
    cyc2(1, 1, 12'h44, 32'h1111_1111, 1, 1, 12'h44, 32'h2222_2222, q0, q1);
    m_mbox[0] = 32'h2222_2222;
    rd(0, 12'h44, q); chk("R10 port1 write wins", q, m_mbox[0]);

    // R5 / R6 interrupt control
    for (int c = 0; c < NC; c++) begin
      for (int k = 0; k < 4; k++) begin
        logic e, f;
        e = k[0]; f = k[1];
        wr(1 - c, 12'h40 + 12'(8 * c), 32'hFFFE_FFFE | (DW'(f) << 16) | DW'(e));
        rd(c, 12'h40 + 12'(8 * c), q);
        chk("R5 irq ctrl readback", q, (DW'(f) << 16) | DW'(e));
        chk("R6 irq output", DW'(irq[c]), DW'(e & f));
        chk("R6 other irq quiet", DW'(irq[1 - c]), 0);
      end
      wr(c, 12'h40 + 12'(8 * c), 0);
    end

    // R8 reserved sweep
    for (int a = 'h20; a < 'h100; a += 4) begin
      if (a >= 'h40 && a < 'h50) continue;
      wr(0, 12'(a), 32'hFFFF_FFFF);
      rd(1, 12'(a), q); chk("R8 reserved reads zero", q, 0);
    end
    chk_status("R8 semaphores untouched");
    for (int c = 0; c < NC; c++) begin
      rd(c, 12'h44 + 12'(8 * c), q); chk("R8 mailbox untouched", q, m_mbox[c]);
      rd(c, 12'h40 + 12'(8 * c), q); chk("R8 irq ctrl untouched", q, 0);
    end
    chk("R8 irq lines quiet", {30'b0, irq}, 0);

    finish_run();
  end
endmodule